// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block holds the program counter of a small 8-bit processor and works out its next value from one control-transfer request per clock. A request names an operation and carries everything that operation needs: the current instruction length, a condition code, a restart number, a branch target, the two halves of the H/L register pair, the address popped from the stack and the processor flags byte. The new counter value is registered and appears one cycle after the request.

Calls and restarts raise a one-cycle push strobe together with the return address the stack engine must save. Returns raise a one-cycle pop strobe and take their destination from the popped address presented with the request. The unit also keeps the halt state and the interrupt-enable flip-flop. While halted it ignores every request. A wake input, driven by whatever logic arbitrates interrupts, ends the halt.

Top module: `pc_next_unit`

## Requirements
- R1: After reset the counter is 0x0000, `halted` and `int_en` are low, and neither strobe is active.
- R2: Request code 0 (sequential), and any code above 11, advances the counter by `req_len` (1, 2 or 3) modulo 2^16. A cycle with `req_valid` low leaves every output unchanged and raises no strobe.
- R3: Code 1 (jump) loads `req_target` into the counter.
- R4: Code 2 (conditional jump) loads `req_target` when the condition holds and otherwise advances by `req_len`. The condition codes are 0 zero clear, 1 zero set, 2 carry clear, 3 carry set, 4 parity odd, 5 parity even, 6 sign clear, 7 sign set. Flags byte bits: sign 7, zero 6, parity 2, carry 0.
- R5: Code 3 (call), and code 4 (conditional call) when its condition holds, loads `req_target`, pulses `push_req` for one cycle and presents the counter plus `req_len` on `ret_addr`. A conditional call whose condition fails advances by `req_len` with no strobe.
- R6: Code 5 (return), and code 6 (conditional return) when its condition holds, loads `pop_data` and pulses `pop_req` for one cycle. A conditional return whose condition fails advances by `req_len` with no strobe.
- R7: Code 7 (restart) loads `req_vec` times eight (0x0000 to 0x0038) and pushes the counter plus `req_len` like a call.
- R8: Code 8 loads the counter with `hl_high` as the upper byte and `hl_low` as the lower byte.
- R9: Code 9 (halt) advances the counter past the halt and sets `halted`. While halted, requests change nothing and raise no strobe.
- R10: `wake` high while halted clears `halted` on the next edge, and the request in that same cycle is ignored.
- R11: Code 10 clears `int_en` and code 11 sets it; both advance the counter by `req_len`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 4 | Operation code |
| req_len | input | 2 | Length of the current instruction in bytes |
| req_cond | input | 3 | Condition code for conditional operations |
| req_vec | input | 3 | Restart number |
| req_target | input | 16 | Jump or call target |
| hl_high | input | 8 | Upper byte of the H/L pair |
| hl_low | input | 8 | Lower byte of the H/L pair |
| pop_data | input | 16 | Address popped from the stack |
| flags | input | 8 | Processor flags byte |
| wake | input | 1 | Leave the halt state |
| pc | output | 16 | Current program counter |
| push_req | output | 1 | Push `ret_addr` this cycle |
| ret_addr | output | 16 | Return address to be pushed |
| pop_req | output | 1 | The stack top was consumed |
| halted | output | 1 | Halt state |
| int_en | output | 1 | Interrupt-enable flip-flop |

## Verification
Every condition code is run twice against the conditional jump, once with a flags byte that satisfies it and once with its complement, so a swapped bit position or inverted sense shows up as a wrong target. Conditional calls and returns are run with both outcomes to separate stack-strobe activity from the fall-through path. Sequential advances use all three lengths, including a wrap past 0xFFFF. Restart numbers 0, 5 and 7 pin down the vector scaling, and a halt is followed by requests of each kind, then a wake that arrives with a competing request.

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_op,
  input  logic [1:0]    req_len,
  input  logic [2:0]    req_cond,
  input  logic [2:0]    req_vec,
  input  logic [AW-1:0] req_target,
  input  logic [BW-1:0] hl_high,
  input  logic [BW-1:0] hl_low,
  input  logic [AW-1:0] pop_data,
  input  logic [BW-1:0] flags,
  input  logic          wake,
  output logic [AW-1:0] pc,
  output logic          push_req,
  output logic [AW-1:0] ret_addr,
  output logic          pop_req,
  output logic          halted,
  output logic          int_en
);
  localparam int FS = 7, FZ = 6, FP = 2, FC = 0;
  localparam logic [3:0] OP_SEQ = 4'd0, OP_JMP = 4'd1, OP_JCC = 4'd2, OP_CALL = 4'd3,
                         OP_CCC = 4'd4, OP_RET = 4'd5, OP_RCC = 4'd6, OP_RST = 4'd7,
                         OP_LHL = 4'd8, OP_HLT = 4'd9, OP_DI = 4'd10, OP_EI = 4'd11;

  logic          cond_ok;
  logic          take;
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] vec_pc;
  logic [AW-1:0] nxt_pc;
  logic          nxt_push, nxt_pop;

  assign take   = req_valid && !halted;
  assign seq_pc = pc + AW'(req_len);
  assign vec_pc = AW'({req_vec, 3'b000});

  always_comb begin
    case (req_cond)
      3'd0: cond_ok = !flags[FZ];
      3'd1: cond_ok =  flags[FZ];
      3'd2: cond_ok = !flags[FC];
      3'd3: cond_ok =  flags[FC];
      3'd4: cond_ok = !flags[FP];
      3'd5: cond_ok =  flags[FP];
      3'd6: cond_ok = !flags[FS];
      default: cond_ok = flags[FS];
    endcase
  end

  always_comb begin
    nxt_pc   = seq_pc;
    nxt_push = 1'b0;
    nxt_pop  = 1'b0;
    case (req_op)
      OP_JMP:  nxt_pc = req_target;
      OP_JCC:  if (cond_ok) nxt_pc = req_target;
      OP_CALL: begin nxt_pc = req_target; nxt_push = 1'b1; end
      OP_CCC:  if (cond_ok) begin nxt_pc = req_target; nxt_push = 1'b1; end
      OP_RET:  begin nxt_pc = pop_data; nxt_pop = 1'b1; end
      OP_RCC:  if (cond_ok) begin nxt_pc = pop_data; nxt_pop = 1'b1; end
      OP_RST:  begin nxt_pc = vec_pc; nxt_push = 1'b1; end
      OP_LHL:  nxt_pc = {hl_high, hl_low};
      default: nxt_pc = seq_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc       <= '0;
      push_req <= 1'b0;
      pop_req  <= 1'b0;
      ret_addr <= '0;
      halted   <= 1'b0;
      int_en   <= 1'b0;
    end else begin
      push_req <= take && nxt_push;
      pop_req  <= take && nxt_pop;
      if (halted && wake) halted <= 1'b0;
      if (take) begin
        pc <= nxt_pc;
        if (nxt_push) ret_addr <= seq_pc;
        if (req_op == OP_HLT) halted <= 1'b1;
        if (req_op == OP_DI)  int_en <= 1'b0;
        if (req_op == OP_EI)  int_en <= 1'b1;
      end
    end
  end

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wake) |=> ($stable(pc) && !push_req && !pop_req));
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_req && pop_req));
  // R7
  rst_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !halted && req_op == OP_RST) |=> (pc[2:0] == 3'b000 && pc[AW-1:6] == '0 && push_req));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !(halted && wake)) |=> ($stable(pc) && $stable(halted) && $stable(int_en) && !push_req && !pop_req));
  // R11
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !halted && req_op == OP_DI) |=> !int_en);
  // R10
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && wake) |=> (!halted && $stable(pc)));
endmodule

// File: tb/test_pc_next_unit.sv
`timescale 1ns/1ps
module test_pc_next_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_op = '0;
  logic [1:0]  req_len = 2'd1;
  logic [2:0]  req_cond = '0;
  logic [2:0]  req_vec = '0;
  logic [15:0] req_target = '0;
  logic [7:0]  hl_high = '0, hl_low = '0;
  logic [15:0] pop_data = '0;
  logic [7:0]  flags = '0;
  logic        wake = 1'b0;
  logic [15:0] pc, ret_addr;
  logic        push_req, pop_req, halted, int_en;

  int checks = 0, errors = 0;
  logic [35:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] m_pc = '0;
  logic        m_halt = 1'b0, m_ie = 1'b0;
  logic [15:0] m_ret = '0;

  always #2.5 clk = ~clk;

  pc_next_unit i_pc_next_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_len(req_len),
    .req_cond(req_cond), .req_vec(req_vec), .req_target(req_target), .hl_high(hl_high),
    .hl_low(hl_low), .pop_data(pop_data), .flags(flags), .wake(wake), .pc(pc),
    .push_req(push_req), .ret_addr(ret_addr), .pop_req(pop_req), .halted(halted), .int_en(int_en));

  function automatic logic cond_true(input logic [2:0] c, input logic [7:0] f);
    case (c)
      3'd0: return !f[6];
      3'd1: return  f[6];
      3'd2: return !f[0];
      3'd3: return  f[0];
      3'd4: return !f[2];
      3'd5: return  f[2];
      3'd6: return !f[7];
      default: return f[7];
    endcase
  endfunction

  task automatic drive(input string tag, input logic v, input logic [3:0] op, input logic [1:0] len,
                       input logic [2:0] cnd, input logic [2:0] vec, input logic [15:0] tgt,
                       input logic [15:0] hl, input logic [15:0] pd, input logic [7:0] fl, input logic wk);
    logic push = 1'b0, pop = 1'b0;
    logic [15:0] seq;
    @(negedge clk);
    req_valid = v; req_op = op; req_len = len; req_cond = cnd; req_vec = vec;
    req_target = tgt; hl_high = hl[15:8]; hl_low = hl[7:0]; pop_data = pd; flags = fl; wake = wk;
    seq = m_pc + 16'(len);
    if (m_halt) begin
      if (wk) m_halt = 1'b0;
    end else if (v) begin
      case (op)
        4'd1: m_pc = tgt;
        4'd2: m_pc = cond_true(cnd, fl) ? tgt : seq;
        4'd3: begin m_pc = tgt; push = 1'b1; end
        4'd4: if (cond_true(cnd, fl)) begin m_pc = tgt; push = 1'b1; end else m_pc = seq;
        4'd5: begin m_pc = pd; pop = 1'b1; end
        4'd6: if (cond_true(cnd, fl)) begin m_pc = pd; pop = 1'b1; end else m_pc = seq;
        4'd7: begin m_pc = {10'd0, vec, 3'd0}; push = 1'b1; end
        4'd8: m_pc = hl;
        4'd9: begin m_pc = seq; m_halt = 1'b1; end
        4'd10: begin m_pc = seq; m_ie = 1'b0; end
        4'd11: begin m_pc = seq; m_ie = 1'b1; end
        default: m_pc = seq;
      endcase
      if (push) m_ret = seq;
    end
    exp_q.push_back({m_pc, push, m_ret, pop, m_halt, m_ie});
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [35:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (pc !== e[35:20] || push_req !== e[19] || (e[19] && ret_addr !== e[18:3]) ||
          pop_req !== e[2] || halted !== e[1] || int_en !== e[0]) begin
        errors++;
        $display("FAIL %s: pc=%h push=%b ret=%h pop=%b halt=%b ie=%b expected pc=%h push=%b ret=%h pop=%b halt=%b ie=%b",
                 t, pc, push_req, ret_addr, pop_req, halted, int_en,
                 e[35:20], e[19], e[18:3], e[2], e[1], e[0]);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    checks++;
    // R1 reset state
    if (pc !== 16'h0 || halted !== 1'b0 || int_en !== 1'b0 || push_req !== 1'b0 || pop_req !== 1'b0) begin
      errors++;
      $display("FAIL R1: pc=%h halt=%b ie=%b push=%b pop=%b expected 0000 0 0 0 0", pc, halted, int_en, push_req, pop_req);
    end
    // R2 sequential lengths, idle, wrap, unused code
    drive("R2", 1, 4'd0, 2'd1, 0, 0, 0, 0, 0, 0, 0);
    drive("R2", 1, 4'd0, 2'd2, 0, 0, 0, 0, 0, 0, 0);
    drive("R2", 1, 4'd0, 2'd3, 0, 0, 0, 0, 0, 0, 0);
    drive("R2", 0, 4'd1, 2'd3, 0, 0, 16'h1234, 0, 0, 0, 0);
    drive("R2", 1, 4'd14, 2'd2, 0, 0, 16'h1234, 0, 0, 0, 0);
    // R3 jump then wrap
    drive("R3", 1, 4'd1, 2'd3, 0, 0, 16'hFFFE, 0, 0, 0, 0);
    drive("R2", 1, 4'd0, 2'd3, 0, 0, 0, 0, 0, 0, 0);
    // R4 every condition both ways
    for (int c = 0; c < 8; c++) begin
      logic [7:0] fsat;
      case (c)
        0: fsat = 8'h00; 1: fsat = 8'h40; 2: fsat = 8'h00; 3: fsat = 8'h01;
        4: fsat = 8'h00; 5: fsat = 8'h04; 6: fsat = 8'h00; default: fsat = 8'h80;
      endcase
      drive("R4", 1, 4'd2, 2'd3, 3'(c), 0, 16'h4000 + 16'(c), 0, 0, fsat, 0);
      drive("R4", 1, 4'd2, 2'd3, 3'(c), 0, 16'h5000 + 16'(c), 0, 0, ~fsat, 0);
    end
    // R5 call, conditional call both ways
    drive("R5", 1, 4'd3, 2'd3, 0, 0, 16'h2100, 0, 0, 0, 0);
    drive("R5", 1, 4'd4, 2'd3, 3'd3, 0, 16'h2200, 0, 0, 8'h01, 0);
    drive("R5", 1, 4'd4, 2'd3, 3'd3, 0, 16'h2300, 0, 0, 8'hFE, 0);
    // R6 return, conditional return both ways
    drive("R6", 1, 4'd5, 2'd1, 0, 0, 0, 0, 16'h3456, 0, 0);
    drive("R6", 1, 4'd6, 2'd1, 3'd7, 0, 0, 0, 16'h789A, 8'h80, 0);
    drive("R6", 1, 4'd6, 2'd1, 3'd7, 0, 0, 0, 16'hBCDE, 8'h7F, 0);
    // R7 restarts
    drive("R7", 1, 4'd7, 2'd1, 0, 3'd5, 0, 0, 0, 0, 0);
    drive("R7", 1, 4'd7, 2'd1, 0, 3'd7, 0, 0, 0, 0, 0);
    drive("R7", 1, 4'd7, 2'd1, 0, 3'd0, 0, 0, 0, 0, 0);
    // R8 load from pair
    drive("R8", 1, 4'd8, 2'd1, 0, 0, 0, 16'hA55A, 0, 0, 0);
    // R11 enable and disable
    drive("R11", 1, 4'd11, 2'd1, 0, 0, 0, 0, 0, 0, 0);
    drive("R11", 1, 4'd10, 2'd1, 0, 0, 0, 0, 0, 0, 0);
    drive("R11", 1, 4'd11, 2'd1, 0, 0, 0, 0, 0, 0, 0);
    // R9 halt, then requests ignored
    drive("R9", 1, 4'd9, 2'd1, 0, 0, 0, 0, 0, 0, 0);
    drive("R9", 1, 4'd1, 2'd3, 0, 0, 16'h1111, 0, 0, 0, 0);
    drive("R9", 1, 4'd3, 2'd3, 0, 0, 16'h2222, 0, 0, 0, 0);
    drive("R9", 1, 4'd5, 2'd1, 0, 0, 0, 0, 16'h3333, 0, 0);
    drive("R9", 1, 4'd10, 2'd1, 0, 0, 0, 0, 0, 0, 0);
    // R10 wake with a competing request, then resume
    drive("R10", 1, 4'd1, 2'd3, 0, 0, 16'h4444, 0, 0, 0, 1);
    drive("R10", 1, 4'd1, 2'd3, 0, 0, 16'h5555, 0, 0, 0, 0);
    drive("R10", 0, 4'd0, 2'd1, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule